// File: doc/BRIEF.md
# Vectored Interrupt Address Table

This block keeps one handler address per interrupt source, 32 sources in all, and hands the processor the address that belongs to the source being serviced. Software loads the entries through a simple write-only register port: an entry index, a data word and a write strobe. The bits of an entry below bit 2 are always zero, and so are the bits at or above the configured address width. Entries for a reserved group of sources and for external sources that are not populated cannot be written.

A 32-bit vector of pending interrupts, already masked and qualified upstream, feeds a lowest-index-first picker. While the block is idle and any source is pending, it raises an interrupt request and latches the chosen entry onto the address output. Request and address stay frozen until the processor pulses acknowledge; the block then goes idle for one cycle before it presents the next pending source. The whole table exists only when the fast-mode parameter is 1. Otherwise the handshake still runs but the address output stays zero.

Top module: `vit_top`

## Requirements
- R1: After reset every table entry is zero, `irq_o` is low and `irq_addr_o` is zero.
- R2: A write with `wr_en_i` high stores `wr_data_i` into the entry selected by `wr_idx_i`, which is an entry number 0..31 and not a byte address. Bits 1:0 and all bits at or above `VEC_W` of a stored entry read as zero on `irq_addr_o`.
- R3: Writes to entries 11, 12, 13, 14 and 15 are ignored, and such an entry presents zero.
- R4: Writes to any entry above 15 + `EXT_SRC` are ignored, and such an entry presents zero.
- R5: When the block is idle and `pend_i` is nonzero at a clock edge, `irq_o` is high after that edge and `irq_addr_o` holds the entry of the lowest-numbered set bit of `pend_i`.
- R6: While `irq_o` is high and `irq_ack_i` is low, `irq_o` stays high and `irq_addr_o` does not change, even when `pend_i` changes or the granted entry is rewritten.
- R7: `irq_ack_i` high at an edge while `irq_o` is high drops `irq_o` after that edge. If `pend_i` is nonzero at the following edge, the next grant is presented after it.
- R8: With `FAST_EN` = 0 the request handshake behaves as in R5 to R7, but `irq_addr_o` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write strobe |
| wr_idx_i | input | 5 | Entry number to write |
| wr_data_i | input | 32 | Handler address to store |
| pend_i | input | 32 | Qualified pending interrupts, bit N is source N |
| irq_ack_i | input | 1 | Acknowledge pulse from the processor |
| irq_o | output | 1 | Interrupt request |
| irq_addr_o | output | 32 | Handler address of the granted source |

## Verification
The assertions assume that `irq_ack_i` is asserted only while `irq_o` is high, and that `pend_i` is a qualified level that the processor clears by the time it acknowledges. The hold check also assumes that nothing writes the entry being granted in the very cycle it is captured. The stimulus drives every input at the falling edge. It pulses acknowledge only after it has seen the request, and it clears the serviced pending bit in the same cycle as the acknowledge. All table writes finish before the pending bits that select those entries are raised. The one exception is the deliberate rewrite of an entry that is already granted and held.

// File: rtl/vit_pkg.sv
package vit_pkg;
  typedef enum logic {
    ST_IDLE,
    ST_HOLD
  } hold_st_e;

  localparam int RSV_LO = 11;
  localparam int RSV_HI = 15;

  // entry may be written: not reserved and within populated external range
  function automatic bit entry_writable(int idx, int ext_src);
    return ((idx < RSV_LO) || (idx > RSV_HI)) && (idx <= RSV_HI + ext_src);
  endfunction
endpackage

// File: rtl/vit_store.sv
module vit_store
  import vit_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = 5,
  parameter int DATA_W  = 32,
  parameter int VEC_W   = 16,
  parameter int EXT_SRC = 8,
  parameter bit FAST_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] vec_o
);
  logic [DATA_W-1:0] tbl [NUM_SRC];

  if (FAST_EN) begin : g_fast
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_ent
      if (entry_writable(i, EXT_SRC)) begin : g_rw
        logic [VEC_W-1:2] keep_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) keep_q <= '0;
          else if (wr_en_i && (wr_idx_i == IDX_W'(i))) keep_q <= wr_data_i[VEC_W-1:2];
        end
        always_comb begin
          tbl[i] = '0;
          tbl[i][VEC_W-1:2] = keep_q;
        end
      end else begin : g_ro
        assign tbl[i] = '0;
      end
    end
    logic unused_wr;
    assign unused_wr = ^wr_data_i;
    assign vec_o = tbl[rd_idx_i];
  end else begin : g_slow
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_ent
      assign tbl[i] = '0;
    end
    logic unused_in;
    assign unused_in = ^{clk_i, rst_ni, wr_en_i, wr_idx_i, wr_data_i, rd_idx_i, tbl[0]};
    assign vec_o = '0;
  end
endmodule

// File: rtl/vit_pick.sv
module vit_pick #(
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  // R5
  pick_is_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> pend_i[idx_o]);
  // R5
  pick_is_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> ((pend_i & ((NUM_SRC'(1) << idx_o) - NUM_SRC'(1))) == '0));
endmodule

// File: rtl/vit_hold.sv
module vit_hold
  import vit_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              any_i,
  input  logic [DATA_W-1:0] vec_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [DATA_W-1:0] addr_o
);
  hold_st_e          st_q;
  logic [DATA_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (any_i) begin
          st_q   <= ST_HOLD;
          addr_q <= vec_i;
        end
        ST_HOLD: if (ack_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign irq_o  = (st_q == ST_HOLD);
  assign addr_o = addr_q;

  // R6
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i) |=> (irq_o && $stable(addr_o)));
  // R7
  ack_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ack_i) |=> !irq_o);
  // R5
  raise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(any_i));
endmodule

// File: rtl/vit_top.sv
module vit_top #(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int VEC_W   = 16,
  parameter int EXT_SRC = 8,
  parameter bit FAST_EN = 1'b1,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic               irq_ack_i,
  output logic               irq_o,
  output logic [DATA_W-1:0]  irq_addr_o
);
  logic              any;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] vec;

  vit_store #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .DATA_W(DATA_W),
    .VEC_W(VEC_W), .EXT_SRC(EXT_SRC), .FAST_EN(FAST_EN)
  ) store_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
    .wr_data_i(wr_data_i), .rd_idx_i(idx), .vec_o(vec)
  );

  vit_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) pick_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pend_i(pend_i), .any_o(any), .idx_o(idx)
  );

  vit_hold #(.DATA_W(DATA_W)) hold_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .any_i(any), .vec_i(vec), .ack_i(irq_ack_i),
    .irq_o(irq_o), .addr_o(irq_addr_o)
  );

  // R2
  addr_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_addr_o[1:0] == 2'b00);
  // R2
  addr_high_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_addr_o >> VEC_W) == '0);
  // R8
  slow_addr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !FAST_EN |-> (irq_addr_o == '0));
endmodule

// File: tb/vit_top_tb_top.sv
module vit_top_tb_top;
  localparam int VEC_W = 16;
  localparam int EXT_SRC = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] pend = '0, pend_s = '0;
  logic        ack = 1'b0, ack_s = 1'b0;
  logic        irq, irq_s;
  logic [31:0] addr, addr_s;

  int checks = 0, errors = 0;
  logic [31:0] exp_tab [32];
  logic [31:0] exp_q [$];
  logic        irq_prev = 1'b0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  vit_top #(.VEC_W(VEC_W), .EXT_SRC(EXT_SRC), .FAST_EN(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .pend_i(pend), .irq_ack_i(ack), .irq_o(irq), .irq_addr_o(addr));

  vit_top #(.VEC_W(VEC_W), .EXT_SRC(EXT_SRC), .FAST_EN(1'b0)) dut_nf_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .pend_i(pend_s), .irq_ack_i(ack_s), .irq_o(irq_s), .irq_addr_o(addr_s));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit writable(int i);
    return ((i < 11) || (i > 15)) && (i <= 15 + EXT_SRC);
  endfunction

  // monitor: pop expected vector on every new request
  always @(negedge clk) begin
    if (rst_ni && irq && !irq_prev) begin
      if (exp_q.size() == 0) check(1'b0, "R5 unexpected grant", addr, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(addr == e, "R5 grant vector", addr, e);
      end
    end
    irq_prev <= irq;
  end

  task automatic wr(input int i, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'(i); wr_data = d;
    if (writable(i)) exp_tab[i] = d & (((32'h1 << VEC_W) - 1) & ~32'h3);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // raise pend bits and push expected vectors lowest first
  task automatic raise(input logic [31:0] m);
    for (int i = 0; i < 32; i++) if (m[i]) exp_q.push_back(exp_tab[i]);
    pend = pend | m;
  endtask

  task automatic serve_one();
    int lo;
    int n = 0;
    @(negedge clk);
    while (!irq && n < 50) begin @(negedge clk); n++; end
    check(irq, "R5 request raised", {31'b0, irq}, 32'h1);
    lo = 0;
    while (lo < 31 && !pend[lo]) lo++;
    ack = 1'b1;
    pend[lo] = 1'b0;
    @(negedge clk);
    ack = 1'b0;
    check(!irq, "R7 drop after ack", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) exp_tab[i] = '0;
    repeat (3) @(negedge clk);
    // R1
    check(!irq && addr == 0, "R1 reset outputs", addr, 32'h0);
    rst_ni = 1'b1;
    // R1: entries read zero before any write
    raise(32'h0000_0001);
    serve_one();
    // R2 R3 R4: load every entry with all-ones tails
    for (int i = 0; i < 32; i++) wr(i, 32'hFFF0_0003 | (32'(i) << 4) | 32'h5400);
    for (int i = 0; i < 32; i++) begin
      raise(32'h1 << i);
      serve_one();
    end
    check(exp_q.size() == 0, "R2 R3 R4 all grants seen", 32'(exp_q.size()), 32'h0);
    // R5 R7: all pending, drained lowest first
    raise(32'hFFFF_FFFF);
    for (int i = 0; i < 32; i++) serve_one();
    // R7: back-to-back grant one cycle after ack
    raise(32'h0001_0004);
    serve_one();
    @(negedge clk);
    check(irq && addr == exp_tab[16], "R7 next grant", addr, exp_tab[16]);
    irq_prev = 1'b1;
    void'(exp_q.pop_front());
    ack = 1'b1; pend = '0;
    @(negedge clk);
    ack = 1'b0;
    // R6: hold against new lower pend and rewrite
    raise(32'h0010_0000);
    @(negedge clk); @(negedge clk);
    check(irq && addr == exp_tab[20], "R6 grant 20", addr, exp_tab[20]);
    begin
      logic [31:0] held;
      held = addr;
      pend[3] = 1'b1;
      wr(20, 32'h0000_ABC8);
      repeat (3) begin
        @(negedge clk);
        check(irq && addr == held, "R6 held", addr, held);
      end
    end
    exp_q.push_back(exp_tab[3]);
    pend[20] = 1'b0;
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    @(negedge clk);
    ack = 1'b1; pend = '0;
    @(negedge clk);
    ack = 1'b0;
    // R8: no table without fast mode
    pend_s = 32'h0000_0001;
    repeat (2) @(negedge clk);
    check(irq_s && addr_s == 0, "R8 slow grant", addr_s, 32'h0);
    ack_s = 1'b1; pend_s = '0;
    @(negedge clk);
    ack_s = 1'b0;
    check(!irq_s, "R8 slow ack", {31'b0, irq_s}, 32'h0);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R5 scoreboard empty", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule